// File: doc/BRIEF.md
# Rotating Thermometer Element Group Selector

This block sits between the successive-approximation logic of a converter and the fifteen equal-weight unit elements that carry its four most significant bits. It splits the unit elements into four contiguous runs of eight, four, two and one element. Those runs stand in for the binary-weighted top bits, largest first. A 4-bit selection code sets where the first run starts on the circular element list. Every code step moves all four runs along by one element, and the list wraps from element 15 back to element 1. The element drive vector sets each element according to the decision bit of the group that owns it.

The code comes from one of two sources. In static mode it is taken from a configuration input, so a single combination chosen during calibration can stay in use for the whole operation. In random mode a 4-bit maximal-length LFSR supplies it, so consecutive conversions use different combinations. The code is latched only on the conversion-start strobe, so the groups hold still during a conversion. The interface has no data stream, only control: there is no valid/ready pair and no back-pressure. The decision bits pass through combinationally to the element drive.

Top module: `therm_group_rotator`

## Requirements
- R1: In reset, and until the first conversion-start strobe, the active code is 0001: grp_mask[3] = 15'h00FF, grp_mask[2] = 15'h0F00, grp_mask[1] = 15'h3000, grp_mask[0] = 15'h4000. The LFSR is seeded to 0001.
- R2: For every code the four masks are disjoint and cover all 15 elements. The population counts are 8 for grp_mask[3], 4 for grp_mask[2], 2 for grp_mask[1] and 1 for grp_mask[0].
- R3: Mask bit i stands for element i+1. With active code k, offset k-1 and relative position p = (i - (k-1)) mod 15, an element belongs to grp_mask[3] for p 0..7, to grp_mask[2] for p 8..11, to grp_mask[1] for p 12..13 and to grp_mask[0] for p 14. Code 0010 gives 15'h01FE, 15'h1E00, 15'h6000 and 15'h0001.
- R4: A static code of 0000 is treated as 0001, and the active code is never 0000.
- R5: The active code changes only on a clock edge where conv_start is 1. The masks do not change in other cycles, even when static_code or mode_rand change.
- R6: With mode_rand = 1, a strobe loads the present LFSR state as the code and then steps the LFSR. The step is a left shift that inserts bit3 XOR bit2 (x^4+x^3+1). After reset the codes come out as 0001, 0010, 0100, 1001, … and repeat every 15 strobes.
- R7: elem_drive[i] is 1 exactly when msb_bits[g] is 1 for the group g whose mask owns element i. msb_bits[3] is the decision for the eight-element group. The drive follows msb_bits in the same cycle.
- R8: The number of set bits in elem_drive equals 8·msb_bits[3] + 4·msb_bits[2] + 2·msb_bits[1] + msb_bits[0].
- R9: The LFSR steps only on strobes taken in random mode. A static-mode strobe between random strobes leaves the random sequence where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_rand | input | 1 | 1 selects the LFSR code, 0 selects static_code |
| static_code | input | 4 | Fixed selection code used in static mode |
| conv_start | input | 1 | Conversion-start strobe; latches the active code |
| msb_bits | input | 4 | Top four decisions, bit 3 most significant |
| grp_mask | output | 4×15 | Group masks; grp_mask[g] has 2^g elements |
| elem_drive | output | 15 | Per-element drive |

## Verification
The static sweep strobes every code from 0000 to 1111 while msb_bits changes. This separates a wrong rotation offset, wrong wrap-around and a wrong zero-code substitution, which each show up as a different mask pattern. Hold phases change static_code and mode without a strobe, which shows whether the masks respond to anything other than the strobe. The random runs check the first codes after reset against fixed values and put a static strobe between random strobes, which tells a wrong LFSR tap or seed apart from an LFSR that steps on the wrong strobes. Decision patterns such as 1010, 0101, 0000 and 1111 show whether each decision bit is routed to the right group.

// File: rtl/tgr_pkg.sv
package tgr_pkg;
  // Number of unit elements used for a given number of binary groups
  function automatic int elem_count(input int n_grp);
    return (1 << n_grp) - 1;
  endfunction

  // Size of group g (group 0 is the least significant)
  function automatic int grp_size(input int g);
    return 1 << g;
  endfunction

  // Relative start position of group g on the rotated element ring
  function automatic int grp_start(input int n_grp, input int g);
    return (1 << n_grp) - (1 << (g + 1));
  endfunction
endpackage

// File: rtl/tgr_lfsr.sv
module tgr_lfsr #(
  parameter int W = 4,
  parameter logic [W-1:0] TAPS = 'b1100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  logic [W-1:0] nxt;
  assign nxt = {state[W-2:0], ^(state & TAPS)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= W'(1);
    else if (step) state <= nxt;
  end
endmodule

// File: rtl/tgr_code_reg.sv
module tgr_code_reg #(
  parameter int CW = 4,
  parameter logic [CW-1:0] TAPS = 'b1100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_rand,
  input  logic [CW-1:0] static_code,
  input  logic          conv_start,
  output logic [CW-1:0] act_code
);
  logic [CW-1:0] rnd_code;
  logic [CW-1:0] fixed_code;
  logic          rnd_step;

  assign rnd_step = conv_start & mode_rand;

  tgr_lfsr #(.W(CW), .TAPS(TAPS)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (rnd_step),
    .state (rnd_code)
  );

  // the all-zero code is reserved and folds onto the first rotation
  assign fixed_code = (static_code == '0) ? CW'(1) : static_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          act_code <= CW'(1);
    else if (conv_start) act_code <= mode_rand ? rnd_code : fixed_code;
  end
endmodule

// File: rtl/tgr_mask_gen.sv
module tgr_mask_gen
  import tgr_pkg::*;
#(
  parameter int NUM_GRP = 4,
  localparam int N  = (1 << NUM_GRP) - 1,
  localparam int RW = $clog2(2 * N)
) (
  input  logic [NUM_GRP-1:0]        code,
  output logic [NUM_GRP-1:0][N-1:0] mask
);
  logic [RW-1:0] offset;
  always_comb offset = (code == '0) ? '0 : (RW'(code) - RW'(1));

  for (genvar e = 0; e < N; e++) begin : g_elem
    logic [RW-1:0] sum;
    logic [RW-1:0] rel;
    always_comb begin
      sum = RW'(e + N) - offset;
      rel = (sum >= RW'(N)) ? (sum - RW'(N)) : sum;
    end
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam int LO = grp_start(NUM_GRP, g);
      localparam int HI = LO + grp_size(g);
      if (LO == 0) begin : g_first
        assign mask[g][e] = (rel < RW'(HI));
      end else begin : g_rest
        assign mask[g][e] = (rel >= RW'(LO)) && (rel < RW'(HI));
      end
    end
  end
endmodule

// File: rtl/tgr_drive.sv
module tgr_drive #(
  parameter int NUM_GRP = 4,
  localparam int N = (1 << NUM_GRP) - 1
) (
  input  logic [NUM_GRP-1:0][N-1:0] mask,
  input  logic [NUM_GRP-1:0]        decision,
  output logic [N-1:0]              drive
);
  for (genvar e = 0; e < N; e++) begin : g_elem
    logic [NUM_GRP-1:0] hit;
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      assign hit[g] = mask[g][e] & decision[g];
    end
    assign drive[e] = |hit;
  end
endmodule

// File: rtl/therm_group_rotator.sv
module therm_group_rotator #(
  parameter int NUM_GRP = 4,
  localparam int N = (1 << NUM_GRP) - 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_rand,
  input  logic [NUM_GRP-1:0]        static_code,
  input  logic                      conv_start,
  input  logic [NUM_GRP-1:0]        msb_bits,
  output logic [NUM_GRP-1:0][N-1:0] grp_mask,
  output logic [N-1:0]              elem_drive
);
  logic [NUM_GRP-1:0] act_code;

  tgr_code_reg #(.CW(NUM_GRP), .TAPS(NUM_GRP'('b1100))) u_code (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_rand   (mode_rand),
    .static_code (static_code),
    .conv_start  (conv_start),
    .act_code    (act_code)
  );

  tgr_mask_gen #(.NUM_GRP(NUM_GRP)) u_mask (
    .code (act_code),
    .mask (grp_mask)
  );

  tgr_drive #(.NUM_GRP(NUM_GRP)) u_drv (
    .mask     (grp_mask),
    .decision (msb_bits),
    .drive    (elem_drive)
  );
endmodule

// File: rtl/tgr_checker.sv
module tgr_checker #(
  parameter int NUM_GRP = 4,
  localparam int N = (1 << NUM_GRP) - 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      conv_start,
  input logic [NUM_GRP-1:0]        msb_bits,
  input logic [NUM_GRP-1:0]        act_code,
  input logic [NUM_GRP-1:0][N-1:0] grp_mask,
  input logic [N-1:0]              elem_drive
);
  logic [N-1:0] union_mask;
  int           total_pop;
  int           weight;
  always_comb begin
    union_mask = '0;
    total_pop  = 0;
    weight     = 0;
    for (int g = 0; g < NUM_GRP; g++) begin
      union_mask = union_mask | grp_mask[g];
      total_pop  = total_pop + $countones(grp_mask[g]);
      weight     = weight + (msb_bits[g] ? (1 << g) : 0);
    end
  end

  // R2: full coverage with no overlap
  assert_partition_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (union_mask == {N{1'b1}}) && (total_pop == N));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_size
    assert_group_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grp_mask[g]) == (1 << g));
  end

  assert_code_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_code != '0);

  assert_hold_between_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_start |=> $stable(grp_mask));

  assert_drive_weight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(elem_drive) == weight);
endmodule

bind therm_group_rotator tgr_checker #(.NUM_GRP(NUM_GRP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_start (conv_start),
  .msb_bits   (msb_bits),
  .act_code   (act_code),
  .grp_mask   (grp_mask),
  .elem_drive (elem_drive)
);

// File: tb/sim_therm_group_rotator.sv
module sim_therm_group_rotator;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_rand = 1'b0;
  logic             conv_start = 1'b0;
  logic [3:0]       static_code = 4'd0;
  logic [3:0]       msb_bits = 4'd0;
  logic [3:0][14:0] grp_mask;
  logic [14:0]      elem_drive;

  always #10 clk = ~clk;  // 50 MHz

  therm_group_rotator u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_rand   (mode_rand),
    .static_code (static_code),
    .conv_start  (conv_start),
    .msb_bits    (msb_bits),
    .grp_mask    (grp_mask),
    .elem_drive  (elem_drive)
  );

  int vectors = 0;
  int miscompares = 0;
  int ref_code = 1;
  int ref_lfsr = 1;
  bit done = 1'b0;

  // behavioural reference state
  always @(posedge clk) begin
    if (!rst_n) begin
      ref_code = 1;
      ref_lfsr = 1;
    end else if (conv_start) begin
      if (mode_rand) begin
        ref_code = ref_lfsr;
        ref_lfsr = ((ref_lfsr << 1) & 15) | (((ref_lfsr >> 3) ^ (ref_lfsr >> 2)) & 1);
      end else begin
        ref_code = (static_code == 0) ? 1 : static_code;
      end
    end
  end

  // group index owning element i (3 = eight-element group)
  function automatic int owner(input int code, input int i);
    int off = (code == 0) ? 0 : code - 1;
    int p = (i - off + 15) % 15;
    if (p < 8)  return 3;
    if (p < 12) return 2;
    if (p < 14) return 1;
    return 0;
  endfunction

  function automatic logic [14:0] exp_mask(input int code, input int g);
    logic [14:0] m = '0;
    for (int i = 0; i < 15; i++) m[i] = (owner(code, i) == g);
    return m;
  endfunction

  function automatic logic [14:0] exp_drive(input int code, input logic [3:0] d);
    logic [14:0] v = '0;
    for (int i = 0; i < 15; i++) v[i] = d[owner(code, i)];
    return v;
  endfunction

  task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model every clock, mid low phase
  always @(negedge clk) begin
    #4;
    if (rst_n && !done) begin
      for (int g = 0; g < 4; g++) check("R3", grp_mask[g], exp_mask(ref_code, g));
      check("R7", elem_drive, exp_drive(ref_code, msb_bits));
    end
  end

  task automatic drive(input logic m, input logic [3:0] c, input logic s, input logic [3:0] d);
    @(negedge clk);
    mode_rand = m; static_code = c; conv_start = s; msb_bits = d;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #4000000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    // R1: reset combination
    check("R1", grp_mask[3], 15'h00FF);
    check("R1", grp_mask[2], 15'h0F00);
    check("R1", grp_mask[1], 15'h3000);
    check("R1", grp_mask[0], 15'h4000);
    rst_n = 1'b1;

    // R3 / R4: static sweep over every code
    for (int c = 0; c < 16; c++) begin
      drive(1'b0, 4'(c), 1'b1, 4'(c));
      drive(1'b0, 4'(c), 1'b0, ~4'(c));
      #5;
      if (c == 0) check("R4", grp_mask[3], 15'h00FF);
      if (c == 2) begin
        check("R3", grp_mask[3], 15'h01FE);
        check("R3", grp_mask[2], 15'h1E00);
        check("R3", grp_mask[1], 15'h6000);
        check("R3", grp_mask[0], 15'h0001);
      end
      if (c == 15) check("R3", grp_mask[3], 15'h407F);
    end

    // R5: hold without strobe while code and mode wander
    drive(1'b0, 4'd9, 1'b1, 4'd0);
    for (int k = 0; k < 6; k++) begin
      drive(k[0], 4'(k + 3), 1'b0, 4'(k));
      #5 check("R5", grp_mask[3], 15'h7F01);
    end

    // R7 / R8: decision routing with code 0001
    drive(1'b0, 4'd1, 1'b1, 4'b1010);
    drive(1'b0, 4'd1, 1'b0, 4'b1010);
    #5 check("R7", elem_drive, 15'h30FF);
    drive(1'b0, 4'd1, 1'b0, 4'b0101);
    #5 check("R8", 15'($countones(elem_drive)), 15'd5);
    drive(1'b0, 4'd1, 1'b0, 4'b1111);
    #5 check("R7", elem_drive, 15'h7FFF);
    drive(1'b0, 4'd1, 1'b0, 4'b0000);
    #5 check("R7", elem_drive, 15'h0000);

    // R6: random sequence starts at the seed
    drive(1'b1, 4'd0, 1'b1, 4'd3);
    drive(1'b1, 4'd0, 1'b0, 4'd3);
    #5 check("R6", grp_mask[3], 15'h00FF);
    drive(1'b1, 4'd0, 1'b1, 4'd6);
    drive(1'b1, 4'd0, 1'b0, 4'd6);
    #5 check("R6", grp_mask[3], 15'h01FE);
    drive(1'b1, 4'd0, 1'b1, 4'd12);
    drive(1'b1, 4'd0, 1'b0, 4'd12);
    #5 check("R6", grp_mask[3], 15'h07F8);

    // R9: static strobe does not advance the random sequence
    drive(1'b0, 4'd5, 1'b1, 4'd1);
    drive(1'b1, 4'd5, 1'b1, 4'd2);
    drive(1'b1, 4'd5, 1'b0, 4'd2);
    #5 check("R9", grp_mask[3], 15'h7F01);

    // long random run, back-to-back strobes and gaps
    for (int k = 0; k < 40; k++) begin
      drive(1'b1, 4'(k), 1'b1, 4'(k * 7));
      if (k % 3 == 0) drive(1'b1, 4'(k), 1'b0, 4'(k * 5));
    end
    drive(1'b0, 4'd0, 1'b0, 4'd0);
    drive(1'b0, 4'd0, 1'b0, 4'd0);
    #6;
    finish_run();
  end
endmodule